// File: doc/BRIEF.md
# Addressed Length-Prefixed Frame Node

This block is the slave end of a half-duplex master/slave byte protocol on a shared bus. Each frame opens with a destination address byte and then a length byte. The length counts the whole frame, the two header bytes included. The node watches the received byte stream and keeps track of every frame boundary, including frames meant for other nodes. It hands the payload of frames sent to its own address to local logic, one byte at a time, with first and last markers.

Local logic builds a reply by loading words of one to four bytes. The node splits each word into bytes, least significant byte first, and stores them in a small buffer. After a frame addressed to this node ends, the node waits a set number of bit times so that the master has time to switch its driver to receive. It then raises a transmit request and sends a frame to the master at address 0. When the transmitter has shifted out the last byte, the node releases the bus. An idle gap on the receive side, set in bit times, ends a partial frame and sets the parser hunting for an address again.

Top module: `frame_node`

## Requirements
- R1: Byte 0 of a frame is the destination address and byte 1 is the total frame length L, header included. When the address equals a nonzero `node_addr`, the L-2 payload bytes appear in order on `pl_data`, one cycle after each is received. `pl_first` marks the first of these bytes and `pl_last` marks the final one. `frm_hit` pulses together with the final byte, or together with the length byte's output slot when L = 2.
- R2: A frame addressed to any other value, address 0 included, produces no payload and no `frm_hit`. The node counts exactly L-2 further bytes and treats the next byte as a new address.
- R3: A length byte of 0 or 1 is malformed and produces no output. With the idle timeout enabled, all bytes are ignored until an idle gap ends the frame. With the timeout disabled (`idle_bits` = 0), the next byte is taken as an address straight away.
- R4: With T = `idle_bits` × `bit_period` cycles and T > 0, a frame is abandoned if T or more idle cycles separate two received bytes. An abandoned frame gives no `frm_hit` and the byte after the gap is taken as an address. A gap of T-1 idle cycles keeps the frame alive. With `idle_bits` = 0 no gap aborts a frame.
- R5: A reply word with `rp_nbytes` = n (0 to 4) adds its low n bytes to the reply, least significant byte first. The reply frame on `tx_data` is 0x00, then 2 + N where N is the number of stored bytes, then the stored bytes in order.
- R6: The reply is committed by a word with `rp_last` set. If it is committed when a matching frame ends, `tx_req` rises exactly `guard_bits` × `bit_period` + 2 cycles after the rise of `frm_hit`. `tx_req` stays high until `tx_busy` is low after the last byte has been accepted. `rp_ready` stays low from commit until the reply has been sent.
- R7: A committed reply is never sent without a matching frame. If the reply is not committed when the guard interval ends, it waits for the next matching frame.
- R8: During and right after reset, `pl_valid`, `frm_hit`, `tx_valid` and `tx_req` are low and `rp_ready` is high.
- R9: `tx_valid` is only high while `tx_req` is high. Once `tx_valid` is raised, it and `tx_data` hold until `tx_ready` accepts the byte.
- R10: Reply bytes beyond the buffer depth (2^`BUF_AW`, 32 by default) are discarded. The length byte then counts only the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_addr | input | 8 | This node's address; 0 matches nothing |
| bit_period | input | PER_W | Clock cycles per bit time (at least 1) |
| idle_bits | input | BITS_W | Idle timeout in bit times; 0 disables it |
| guard_bits | input | BITS_W | Turnaround guard in bit times |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_first | output | 1 | First payload byte of a frame |
| pl_last | output | 1 | Last payload byte of a frame |
| frm_hit | output | 1 | Pulse when a matching frame completes |
| rp_valid | input | 1 | Reply word offered |
| rp_word | input | 8*WORD_BYTES | Reply word, sent least significant byte first |
| rp_nbytes | input | NB_W | Number of bytes of the word to use |
| rp_last | input | 1 | This word completes the reply |
| rp_ready | output | 1 | Reply word accepted when high with rp_valid |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_busy | input | 1 | Transmitter shifting; raised the cycle after a take |
| tx_req | output | 1 | Bus driver enable (transmit request) |

## Verification
The bench aims at the idle gap boundary: T-1 idle cycles must keep a frame alive and T must end it. A timer that is off by one either joins the next frame's address to a stale frame or drops a frame that is still valid. Frames for other addresses, address 0 among them, are sent back to back with a matching frame. A skip counter that is wrong by one byte would lose or corrupt the frame that follows. Malformed lengths are tested with the timeout both enabled and disabled, and the reply is checked for its exact header, its least significant byte first order, the exact guard delay, clamping of an overfull buffer, and the rule that it stays silent until a matching frame arrives.

// File: rtl/fn_pkg.sv
package fn_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam logic [7:0]  MASTER_ADDR = 8'h00;
  localparam logic [7:0]  HDR_BYTES   = 8'd2;

  typedef enum logic [2:0] {
    RX_ADDR, RX_LEN, RX_TAKE, RX_SKIP, RX_DROP
  } rx_state_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_GUARD, TX_HDR0, TX_HDR1, TX_FETCH, TX_LOAD, TX_SEND, TX_DRAIN
  } tx_state_e;
endpackage

// File: rtl/fn_bit_timer.sv
// Counts a number of bit times after a restart; done stays high once reached.
module fn_bit_timer #(
  parameter int PER_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PER_W-1:0] bit_period,
  input  logic [CNT_W-1:0] n_bits,
  output logic             done
);
  logic [PER_W-1:0] cyc;
  logic [CNT_W-1:0] bits;
  logic             bit_end;

  assign done    = (bits == n_bits);
  assign bit_end = (bit_period <= PER_W'(1)) || (cyc == bit_period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      bits <= '0;
    end else if (restart) begin
      cyc  <= '0;
      bits <= '0;
    end else if (!done) begin
      if (bit_end) begin
        cyc  <= '0;
        bits <= bits + CNT_W'(1);
      end else begin
        cyc <= cyc + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/fn_rx_parser.sv
// Frame parser: address, total length, payload; skips foreign frames by count.
module fn_rx_parser
  import fn_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       node_addr,
  input  logic [PER_W-1:0] bit_period,
  input  logic [CNT_W-1:0] idle_bits,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             pl_valid,
  output logic [7:0]       pl_data,
  output logic             pl_first,
  output logic             pl_last,
  output logic             frm_hit
);
  rx_state_e  state, cur;
  logic [7:0] rem;
  logic       hit_addr;
  logic       first_q;
  logic       idle_done;
  logic       timeout;

  fn_bit_timer #(.PER_W(PER_W), .CNT_W(CNT_W)) u_idle (
    .clk        (clk),
    .rst        (rst),
    .restart    (rx_valid),
    .bit_period (bit_period),
    .n_bits     (idle_bits),
    .done       (idle_done)
  );

  assign timeout = idle_done && (idle_bits != '0);

  // An expired gap returns the parser to address hunting before the byte is seen.
  always_comb begin
    cur = state;
    if (timeout && state != RX_ADDR) cur = RX_ADDR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_ADDR;
      rem      <= '0;
      hit_addr <= 1'b0;
      first_q  <= 1'b0;
      pl_valid <= 1'b0;
      pl_data  <= '0;
      pl_first <= 1'b0;
      pl_last  <= 1'b0;
      frm_hit  <= 1'b0;
    end else begin
      pl_valid <= 1'b0;
      pl_first <= 1'b0;
      pl_last  <= 1'b0;
      frm_hit  <= 1'b0;
      state    <= cur;
      if (rx_valid) begin
        case (cur)
          RX_ADDR: begin
            hit_addr <= (rx_data == node_addr) && (rx_data != MASTER_ADDR);
            state    <= RX_LEN;
          end
          RX_LEN: begin
            if (rx_data < HDR_BYTES) begin
              state <= (idle_bits == '0) ? RX_ADDR : RX_DROP;
            end else if (rx_data == HDR_BYTES) begin
              frm_hit <= hit_addr;
              state   <= RX_ADDR;
            end else begin
              rem     <= rx_data - HDR_BYTES;
              first_q <= 1'b1;
              state   <= hit_addr ? RX_TAKE : RX_SKIP;
            end
          end
          RX_TAKE: begin
            pl_valid <= 1'b1;
            pl_data  <= rx_data;
            pl_first <= first_q;
            first_q  <= 1'b0;
            pl_last  <= (rem == 8'd1);
            rem      <= rem - 8'd1;
            if (rem == 8'd1) begin
              frm_hit <= 1'b1;
              state   <= RX_ADDR;
            end
          end
          RX_SKIP: begin
            rem <= rem - 8'd1;
            if (rem == 8'd1) state <= RX_ADDR;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fn_reply_store.sv
// Splits reply words into bytes (low byte first) and keeps them in a RAM.
module fn_reply_store #(
  parameter int WORD_BYTES = 4,
  parameter int AW         = 5,
  parameter int NB_W       = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic [WORD_BYTES*8-1:0] wr_word,
  input  logic [NB_W-1:0]         wr_nbytes,
  input  logic                    wr_last,
  output logic                    wr_ready,
  input  logic                    clear,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data,
  output logic                    committed,
  output logic [AW:0]             count
);
  localparam int DEPTH  = 1 << AW;
  localparam int WORD_W = WORD_BYTES * 8;

  logic [7:0]        mem [DEPTH];
  logic [WORD_W-1:0] sh_word;
  logic [NB_W-1:0]   sh_left;
  logic [NB_W-1:0]   nb_clamp;
  logic              sh_last;
  logic              busy;
  logic              full;
  logic              we;

  assign wr_ready = !busy && !committed;
  assign full     = (count == (AW+1)'(DEPTH));
  assign we       = busy && !full;
  assign nb_clamp = (wr_nbytes > NB_W'(WORD_BYTES)) ? NB_W'(WORD_BYTES) : wr_nbytes;

  always_ff @(posedge clk) begin
    if (we) mem[count[AW-1:0]] <= sh_word[7:0];
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_word   <= '0;
      sh_left   <= '0;
      sh_last   <= 1'b0;
      busy      <= 1'b0;
      count     <= '0;
      committed <= 1'b0;
    end else if (busy) begin
      if (!full) count <= count + (AW+1)'(1);
      sh_word <= sh_word >> 8;
      sh_left <= sh_left - NB_W'(1);
      if (sh_left == NB_W'(1)) begin
        busy      <= 1'b0;
        committed <= sh_last;
      end
    end else if (wr_valid && wr_ready) begin
      if (nb_clamp == '0) begin
        committed <= wr_last;
      end else begin
        busy    <= 1'b1;
        sh_word <= wr_word;
        sh_left <= nb_clamp;
        sh_last <= wr_last;
      end
    end
  end
endmodule

// File: rtl/fn_tx_seq.sv
// Waits the guard interval after a matching frame, then sends 0, length, payload.
module fn_tx_seq
  import fn_pkg::*;
#(
  parameter int AW    = 5,
  parameter int PER_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_hit,
  input  logic [PER_W-1:0] bit_period,
  input  logic [CNT_W-1:0] guard_bits,
  input  logic             committed,
  input  logic [AW:0]      count,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             clear,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             tx_busy,
  output logic             tx_req
);
  tx_state_e  state;
  logic       g_done;
  logic       g_start;
  logic [7:0] len_byte;

  assign g_start  = (state == TX_IDLE) && frm_hit;
  assign len_byte = 8'(count) + HDR_BYTES;

  fn_bit_timer #(.PER_W(PER_W), .CNT_W(CNT_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .restart    (g_start),
    .bit_period (bit_period),
    .n_bits     (guard_bits),
    .done       (g_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      rd_addr  <= '0;
      clear    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_req   <= 1'b0;
    end else begin
      clear <= 1'b0;
      case (state)
        TX_IDLE: if (frm_hit) state <= TX_GUARD;
        TX_GUARD: begin
          if (g_done) begin
            if (committed) begin
              tx_req   <= 1'b1;
              tx_valid <= 1'b1;
              tx_data  <= MASTER_ADDR;
              state    <= TX_HDR0;
            end else begin
              state <= TX_IDLE;
            end
          end
        end
        TX_HDR0: if (tx_ready) begin
          tx_data <= len_byte;
          state   <= TX_HDR1;
        end
        TX_HDR1: if (tx_ready) begin
          tx_valid <= 1'b0;
          rd_addr  <= '0;
          state    <= (count == '0) ? TX_DRAIN : TX_FETCH;
        end
        TX_FETCH: state <= TX_LOAD;
        TX_LOAD: begin
          tx_valid <= 1'b1;
          tx_data  <= rd_data;
          state    <= TX_SEND;
        end
        TX_SEND: if (tx_ready) begin
          tx_valid <= 1'b0;
          if ({1'b0, rd_addr} + (AW+1)'(1) == count) begin
            state <= TX_DRAIN;
          end else begin
            rd_addr <= rd_addr + AW'(1);
            state   <= TX_FETCH;
          end
        end
        TX_DRAIN: if (!tx_busy) begin
          tx_req  <= 1'b0;
          clear   <= 1'b1;
          rd_addr <= '0;
          state   <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_node.sv
module frame_node #(
  parameter int WORD_BYTES = 4,
  parameter int BUF_AW     = 5,
  parameter int PER_W      = 16,
  parameter int BITS_W     = 8,
  parameter int NB_W       = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              node_addr,
  input  logic [PER_W-1:0]        bit_period,
  input  logic [BITS_W-1:0]       idle_bits,
  input  logic [BITS_W-1:0]       guard_bits,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic                    pl_valid,
  output logic [7:0]              pl_data,
  output logic                    pl_first,
  output logic                    pl_last,
  output logic                    frm_hit,
  input  logic                    rp_valid,
  input  logic [WORD_BYTES*8-1:0] rp_word,
  input  logic [NB_W-1:0]         rp_nbytes,
  input  logic                    rp_last,
  output logic                    rp_ready,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  input  logic                    tx_ready,
  input  logic                    tx_busy,
  output logic                    tx_req
);
  logic              clear;
  logic              committed;
  logic [BUF_AW:0]   count;
  logic [BUF_AW-1:0] rd_addr;
  logic [7:0]        rd_data;

  fn_rx_parser #(.PER_W(PER_W), .CNT_W(BITS_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .node_addr  (node_addr),
    .bit_period (bit_period),
    .idle_bits  (idle_bits),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .pl_valid   (pl_valid),
    .pl_data    (pl_data),
    .pl_first   (pl_first),
    .pl_last    (pl_last),
    .frm_hit    (frm_hit)
  );

  fn_reply_store #(.WORD_BYTES(WORD_BYTES), .AW(BUF_AW), .NB_W(NB_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (rp_valid),
    .wr_word   (rp_word),
    .wr_nbytes (rp_nbytes),
    .wr_last   (rp_last),
    .wr_ready  (rp_ready),
    .clear     (clear),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .committed (committed),
    .count     (count)
  );

  fn_tx_seq #(.AW(BUF_AW), .PER_W(PER_W), .CNT_W(BITS_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .frm_hit    (frm_hit),
    .bit_period (bit_period),
    .guard_bits (guard_bits),
    .committed  (committed),
    .count      (count),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .clear      (clear),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .tx_busy    (tx_busy),
    .tx_req     (tx_req)
  );
endmodule

// File: rtl/frame_node_chk.sv
module frame_node_chk (
  input logic       clk,
  input logic       rst,
  input logic       pl_valid,
  input logic       pl_first,
  input logic       pl_last,
  input logic       frm_hit,
  input logic       rp_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       tx_req
);
  a_r9_valid_in_req: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_req);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r5_addr_first: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> (tx_valid && tx_data == 8'h00));

  a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    (pl_first || pl_last) |-> pl_valid);

  a_r1_last_is_hit: assert property (@(posedge clk) disable iff (rst)
    pl_last |-> frm_hit);

  a_r6_no_load_while_sending: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> !rp_ready);
endmodule

bind frame_node frame_node_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pl_valid (pl_valid),
  .pl_first (pl_first),
  .pl_last  (pl_last),
  .frm_hit  (frm_hit),
  .rp_ready (rp_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_ready (tx_ready),
  .tx_req   (tx_req)
);

// File: tb/frame_node_tb.sv
module frame_node_tb;
  localparam int P    = 4;
  localparam int IB   = 3;
  localparam int GB   = 2;
  localparam int T    = IB * P;
  localparam logic [7:0] NODE = 8'h2A;

  logic        clk, rst;
  logic [7:0]  node_addr;
  logic [15:0] bit_period;
  logic [7:0]  idle_bits, guard_bits;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        pl_valid, pl_first, pl_last, frm_hit;
  logic [7:0]  pl_data;
  logic        rp_valid, rp_last, rp_ready;
  logic [31:0] rp_word;
  logic [2:0]  rp_nbytes;
  logic        tx_valid, tx_ready, tx_busy, tx_req;
  logic [7:0]  tx_data;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  logic [7:0] pl_buf [1024];
  logic [7:0] exp_pl [1024];
  logic [7:0] tx_buf [1024];
  logic [7:0] exp_tx [64];
  int pl_n = 0, first_n = 0, last_n = 0, hit_n = 0, hit_cyc = 0;
  int exp_n = 0, exp_first = 0, exp_last = 0, exp_hits = 0;
  int tx_n = 0, req_n = 0, req_cyc = 0, bad_r9 = 0, exp_tx_n = 0;
  logic req_prev = 1'b0;
  int bcnt;

  frame_node u_dut (
    .clk(clk), .rst(rst), .node_addr(node_addr), .bit_period(bit_period),
    .idle_bits(idle_bits), .guard_bits(guard_bits),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_first(pl_first), .pl_last(pl_last),
    .frm_hit(frm_hit),
    .rp_valid(rp_valid), .rp_word(rp_word), .rp_nbytes(rp_nbytes), .rp_last(rp_last),
    .rp_ready(rp_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_busy(tx_busy),
    .tx_req(tx_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Transmitter model: takes a byte, busy for six cycles, raises busy the cycle after.
  always @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0; tx_ready <= 1'b0; bcnt <= 0;
    end else if (tx_valid && tx_ready) begin
      tx_busy <= 1'b1; tx_ready <= 1'b0; bcnt <= 5;
    end else if (bcnt != 0) begin
      bcnt <= bcnt - 1;
    end else begin
      tx_busy <= 1'b0; tx_ready <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pl_valid) begin
        if (pl_n < 1024) pl_buf[pl_n] = pl_data;
        pl_n++;
        if (pl_first) first_n++;
        if (pl_last) last_n++;
      end
      if (frm_hit) begin hit_n++; hit_cyc = cyc; end
      if (tx_req && !req_prev) begin req_n++; req_cyc = cyc; end
      req_prev = tx_req;
      if (tx_valid && tx_ready) begin
        if (tx_n < 1024) tx_buf[tx_n] = tx_data;
        tx_n++;
      end
      if (tx_valid && !tx_req) bad_r9++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] addr, input int plen, input int lead, input int gap);
    logic [7:0] b;
    send_byte(addr, lead);
    send_byte(8'(plen + 2), gap);
    for (int i = 0; i < plen; i++) begin
      b = 8'($urandom % 256);
      send_byte(b, gap);
      if (addr == NODE) begin exp_pl[exp_n] = b; exp_n++; end
    end
    if (addr == NODE) begin
      exp_hits++;
      if (plen > 0) begin exp_first++; exp_last++; end
    end
  endtask

  task automatic check_rx(input string tag);
    int mism;
    repeat (3) @(negedge clk);
    mism = 0;
    for (int i = 0; i < exp_n && i < 1024; i++) if (pl_buf[i] !== exp_pl[i]) mism++;
    chk(pl_n == exp_n, {tag, " payload count"}, pl_n, exp_n);
    chk(mism == 0, {tag, " payload bytes"}, mism, 0);
    chk(hit_n == exp_hits, {tag, " frame hits"}, hit_n, exp_hits);
    chk(first_n == exp_first && last_n == exp_last, {tag, " first/last marks"},
        first_n * 1000 + last_n, exp_first * 1000 + exp_last);
  endtask

  task automatic put_word(input logic [31:0] w, input int nb, input bit last);
    @(negedge clk);
    rp_valid = 1'b1; rp_word = w; rp_nbytes = 3'(nb); rp_last = last;
    while (!rp_ready) @(negedge clk);
    @(negedge clk);
    rp_valid = 1'b0; rp_last = 1'b0;
    for (int i = 0; i < nb && i < 4; i++) begin
      if (exp_tx_n < 32) begin exp_tx[exp_tx_n] = w[8*i +: 8]; exp_tx_n++; end
    end
  endtask

  task automatic wait_reply(input string tag);
    int r0, t0, mism, waited;
    r0 = req_n; t0 = tx_n; waited = 0;
    send_frame(NODE, 1, 4, 0);
    while (!(req_n == r0 + 1 && !tx_req) && waited < 3000) begin
      @(negedge clk); waited++;
    end
    chk(req_n == r0 + 1, {tag, " R6 one transmit request"}, req_n - r0, 1);
    chk(req_cyc - hit_cyc == GB * P + 2, {tag, " R6 guard delay"}, req_cyc - hit_cyc, GB * P + 2);
    chk(tx_n - t0 == exp_tx_n + 2, {tag, " R5 reply byte count"}, tx_n - t0, exp_tx_n + 2);
    chk(tx_buf[t0] == 8'h00, {tag, " R5 reply address"}, int'(tx_buf[t0]), 0);
    chk(int'(tx_buf[t0 + 1]) == exp_tx_n + 2, {tag, " R5/R10 length byte"},
        int'(tx_buf[t0 + 1]), exp_tx_n + 2);
    mism = 0;
    for (int i = 0; i < exp_tx_n; i++) if (tx_buf[t0 + 2 + i] !== exp_tx[i]) mism++;
    chk(mism == 0, {tag, " R5 low byte first order"}, mism, 0);
    @(negedge clk);
    chk(rp_ready == 1'b1, {tag, " R6 ready after send"}, int'(rp_ready), 1);
    exp_tx_n = 0;
    check_rx({tag, " R1"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int r0;
    logic [7:0] a;
    void'($urandom(32'd1234));
    rst = 1'b1; rx_valid = 1'b0; rx_data = '0;
    rp_valid = 1'b0; rp_word = '0; rp_nbytes = '0; rp_last = 1'b0;
    node_addr = NODE; bit_period = 16'(P); idle_bits = 8'(IB); guard_bits = 8'(GB);
    repeat (4) @(negedge clk);
    chk(!pl_valid && !frm_hit && !tx_valid && !tx_req, "R8 reset outputs low",
        int'({pl_valid, frm_hit, tx_valid, tx_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rp_ready == 1'b1, "R8 rp_ready after reset", int'(rp_ready), 1);
    chk(!pl_valid && !tx_req, "R8 quiet after reset", int'({pl_valid, tx_req}), 0);

    // R1 directed matching frames, including an empty one
    send_frame(NODE, 4, 2, 0);
    send_frame(NODE, 0, 0, 0);
    check_rx("R1 directed");

    // R2 frame for the master, then a matching frame with no gap
    send_frame(8'h00, 5, 0, 0);
    send_frame(NODE, 3, 0, 0);
    send_frame(8'h2B, 7, 0, 1);
    send_frame(NODE, 2, 0, 1);
    check_rx("R2 back to back");

    // R2 random mix of addresses, lengths and short gaps
    for (int k = 0; k < 24; k++) begin
      case ($urandom % 3)
        0: a = NODE;
        1: a = 8'h00;
        default: begin
          a = 8'($urandom % 256);
          if (a == NODE) a = 8'h55;
        end
      endcase
      send_frame(a, int'($urandom % 9), int'($urandom % 4), int'($urandom % 4));
    end
    check_rx("R2 random");

    // R3 malformed length with timeout enabled: following bytes are dropped
    send_byte(NODE, 2);
    send_byte(8'd1, 0);
    send_byte(NODE, 0); send_byte(8'd4, 0); send_byte(8'hA1, 0); send_byte(8'hA2, 3);
    check_rx("R3 dropped until gap");
    send_frame(NODE, 2, T, 0);
    check_rx("R3 resync after gap");

    // R4 gap of T aborts, the next byte is an address
    send_byte(NODE, T);
    send_byte(8'd6, 0);
    send_byte(8'hC1, 0); send_byte(8'hC2, 0);
    exp_pl[exp_n] = 8'hC1; exp_pl[exp_n + 1] = 8'hC2; exp_n += 2; exp_first++;
    send_frame(NODE, 2, T, 0);
    check_rx("R4 abort at T idle cycles");
    // R4 gap of T-1 keeps the frame
    send_frame(NODE, 3, T, T - 1);
    check_rx("R4 T-1 idle cycles kept");

    // R3/R4 with the timeout disabled
    idle_bits = 8'd0;
    send_byte(NODE, 4);
    send_byte(8'd0, 0);
    send_frame(NODE, 3, 0, 0);
    send_frame(NODE, 2, 0, 40);
    check_rx("R3 R4 timeout disabled");
    idle_bits = 8'(IB);
    repeat (T + 30) @(negedge clk);

    // R7 committed reply stays silent without a matching frame
    r0 = req_n;
    put_word(32'h11223344, 4, 1'b0);
    put_word(32'h0000AABB, 2, 1'b1);
    repeat (4) @(negedge clk);
    chk(rp_ready == 1'b0, "R6 ready low once committed", int'(rp_ready), 0);
    send_frame(8'h2B, 2, 0, 0);
    send_frame(8'h00, 2, 0, 0);
    repeat (60) @(negedge clk);
    chk(req_n == r0, "R7 no request without match", req_n - r0, 0);
    wait_reply("directed");

    // R5 random reply words
    for (int k = 0; k < 3; k++) begin
      int nw;
      nw = 1 + int'($urandom % 3);
      for (int j = 0; j < nw; j++)
        put_word($urandom, int'($urandom % 5), j == nw - 1);
      repeat (6) @(negedge clk);
      wait_reply("random");
    end

    // R10 overfull reply buffer
    for (int j = 0; j < 9; j++) put_word($urandom, 4, j == 8);
    repeat (6) @(negedge clk);
    chk(exp_tx_n == 32, "R10 bench expects 32 stored", exp_tx_n, 32);
    wait_reply("overflow R10");

    // R7 reply committed after the guard lapsed waits for the next match
    r0 = req_n;
    send_frame(NODE, 1, 0, 0);
    repeat (GB * P + 10) @(negedge clk);
    put_word(32'h0000005A, 1, 1'b1);
    repeat (40) @(negedge clk);
    chk(req_n == r0, "R7 late commit held", req_n - r0, 0);
    wait_reply("late commit R7");

    chk(bad_r9 == 0, "R9 tx_valid only under tx_req", bad_r9, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule